// File: doc/BRIEF.md
# USB Token Packet Encoder

This block assembles the byte image of low-speed/full-speed USB token, start-of-frame and handshake packets and feeds it to a byte-wide transmit port of the kind a UTMI transceiver presents. A requester raises `req_i` for one cycle with a 4-bit PID code and either a device address plus endpoint number or an 11-bit frame number. The block captures the request, computes the 5-bit token checksum over the 11-bit field, and streams the PID byte followed, where the packet type needs it, by two field bytes that carry the checksum.

Transmission uses a valid/ready pair. The byte on `tx_data_o` stays put until the transceiver acknowledges it with `tx_ready_i`, and then the next byte is presented. Sync patterns, bit stuffing, NRZI and line drivers belong to the transceiver and are not part of the block.

Top module: `usb_tok_enc`

## Requirements
- R1: The first byte of every packet is `{~pid, pid}`: the PID code is in bits 3:0 and its bitwise complement is in bits 7:4.
- R2: A PID whose two low bits are `2'b10` (handshake: ACK 0010, NAK 1010, STALL 1110, NYET 0110) gives a one-byte packet. Every other PID gives a three-byte packet.
- R3: For a non-SOF PID, the 11-bit field is `{endp_i, addr_i}`. The second byte is `{endp_i[0], addr_i[6:0]}` and bits 2:0 of the third byte are `endp_i[3:1]`.
- R4: For the start-of-frame PID (0101), the field is `frame_i`. The second byte is `frame_i[7:0]` and bits 2:0 of the third byte are `frame_i[10:8]`.
- R5: The checksum uses the generator x^5+x^2+1. The register starts at 5'h1F and takes the field least-significant bit first. The result is complemented and its MSB is placed in bit 3 of the third byte, down to its LSB in bit 7. A SETUP (1101) to address 0, endpoint 0 therefore yields the bytes 2D 00 10.
- R6: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o` and `tx_valid_o` hold their values into the next cycle.
- R7: `tx_valid_o` falls in the cycle after the last byte is accepted. It stays high from the first byte to the last, with no gaps.
- R8: A request that arrives while `busy_o` is high is dropped and does not change the packet in flight.
- R9: During and after reset, `tx_valid_o` and `busy_o` are low.
- R10: A request accepted while idle raises `tx_valid_o` and `busy_o` in the next cycle, with the PID byte on `tx_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Packet request strobe |
| pid_i | input | 4 | PID code |
| addr_i | input | 7 | Device address (token packets) |
| endp_i | input | 4 | Endpoint number (token packets) |
| frame_i | input | 11 | Frame number (start-of-frame packets) |
| tx_ready_i | input | 1 | Transceiver has taken the current byte |
| tx_valid_o | output | 1 | Packet byte valid, held for the whole packet |
| tx_data_o | output | 8 | Current packet byte |
| busy_o | output | 1 | Packet in flight; new requests are ignored |

## Verification
The assertions check the handshake rules on every cycle:
- data is held while stalled;
- an accepted request produces a valid PID byte with matching complement bits in the next cycle;
- the stream drops right after the last accepted byte;
- requests made while busy leave the captured packet unchanged.

Only the bench scenarios can show that the bytes are correct. These cover the checksum values, the field bit placement for token and frame packets, and the length chosen for each PID class. The bench checks them against a bit-serial checksum model, under random transceiver stalls and with requests injected while a packet is in flight.

// File: rtl/usb_tok_pkg.sv
package usb_tok_pkg;
  localparam int PID_W   = 4;
  localparam int ADDR_W  = 7;
  localparam int ENDP_W  = 4;
  localparam int FIELD_W = ADDR_W + ENDP_W;
  localparam int CRC_W   = 5;
  localparam int MAX_LEN = 3;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int IDX_W   = $clog2(MAX_LEN);
  localparam logic [CRC_W-1:0] CRC_POLY = 5'b00101;
  localparam logic [CRC_W-1:0] CRC_SEED = 5'h1f;
  localparam logic [PID_W-1:0] PID_SOF  = 4'b0101;

  typedef logic [7:0] pkt_byte_t;
  typedef pkt_byte_t [MAX_LEN-1:0] pkt_img_t;

  function automatic logic is_handshake(input logic [PID_W-1:0] pid);
    return pid[1:0] == 2'b10;
  endfunction
endpackage

// File: rtl/usb_tok_crc5.sv
module usb_tok_crc5
  import usb_tok_pkg::*;
#(
  parameter int W = FIELD_W
) (
  input  logic [W-1:0]     field_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] st [W+1];
  assign st[0] = CRC_SEED;

  // one serial step per field bit, LSB first
  for (genvar i = 0; i < W; i++) begin : g_step
    logic fb;
    assign fb        = st[i][CRC_W-1] ^ field_i[i];
    assign st[i+1]   = {st[i][CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  assign crc_o = st[W];
endmodule

// File: rtl/usb_tok_pack.sv
module usb_tok_pack
  import usb_tok_pkg::*;
(
  input  logic [PID_W-1:0]   pid_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [ENDP_W-1:0]  endp_i,
  input  logic [FIELD_W-1:0] frame_i,
  output pkt_img_t           img_o,
  output logic [LEN_W-1:0]   len_o
);
  logic [FIELD_W-1:0] field;
  logic [CRC_W-1:0]   crc_raw, crc_inv, crc_wire;

  assign field = (pid_i == PID_SOF) ? frame_i : {endp_i, addr_i};

  usb_tok_crc5 #(.W(FIELD_W)) u_crc (
    .field_i (field),
    .crc_o   (crc_raw)
  );

  assign crc_inv = ~crc_raw;
  // checksum goes out MSB first, bytes go out LSB first
  for (genvar i = 0; i < CRC_W; i++) begin : g_rev
    assign crc_wire[i] = crc_inv[CRC_W-1-i];
  end

  assign img_o[0] = {~pid_i, pid_i};
  assign img_o[1] = field[7:0];
  assign img_o[2] = {crc_wire, field[FIELD_W-1:8]};
  assign len_o    = is_handshake(pid_i) ? LEN_W'(1) : LEN_W'(MAX_LEN);
endmodule

// File: rtl/usb_tok_tx.sv
module usb_tok_tx
  import usb_tok_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  pkt_img_t         img_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             tx_ready_i,
  output logic             tx_valid_o,
  output pkt_byte_t        tx_data_o,
  output logic             busy_o
);
  pkt_img_t          img_q;
  logic [LEN_W-1:0]  len_q;
  logic [IDX_W-1:0]  idx_q;
  logic              valid_q;
  logic              last;

  assign last = (LEN_W'(idx_q) == len_q - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      img_q   <= '0;
      len_q   <= '0;
    end else if (!valid_q) begin
      if (req_i) begin
        valid_q <= 1'b1;
        img_q   <= img_i;
        len_q   <= len_i;
        idx_q   <= '0;
      end
    end else if (tx_ready_i) begin
      if (last) valid_q <= 1'b0;
      else      idx_q   <= idx_q + IDX_W'(1);
    end
  end

  always_comb begin
    tx_data_o = img_q[0];
    for (int i = 1; i < MAX_LEN; i++)
      if (idx_q == IDX_W'(i)) tx_data_o = img_q[i];
  end

  assign tx_valid_o = valid_q;
  assign busy_o     = valid_q;

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)); // R6
  AST_START_PID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o |=> tx_valid_o && (tx_data_o[7:4] == ~tx_data_o[3:0])); // R10
  AST_DROP_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && last |=> !tx_valid_o); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && req_i |=> $stable(img_q) && $stable(len_q)); // R8
  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (LEN_W'(idx_q) < len_q) && (len_q == LEN_W'(1) || len_q == LEN_W'(MAX_LEN))); // R2
endmodule

// File: rtl/usb_tok_enc.sv
module usb_tok_enc
  import usb_tok_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [3:0]  pid_i,
  input  logic [6:0]  addr_i,
  input  logic [3:0]  endp_i,
  input  logic [10:0] frame_i,
  input  logic        tx_ready_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        busy_o
);
  pkt_img_t         img;
  logic [LEN_W-1:0] len;

  usb_tok_pack u_pack (
    .pid_i   (pid_i),
    .addr_i  (addr_i),
    .endp_i  (endp_i),
    .frame_i (frame_i),
    .img_o   (img),
    .len_o   (len)
  );

  usb_tok_tx u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .img_i      (img),
    .len_i      (len),
    .tx_ready_i (tx_ready_i),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .busy_o     (busy_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |=> !tx_valid_o && !busy_o); // R9
endmodule

// File: tb/usb_tok_enc_test.sv
module usb_tok_enc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [3:0]  pid = '0;
  logic [6:0]  addr = '0;
  logic [3:0]  endp = '0;
  logic [10:0] frame = '0;
  logic        ready = 1'b1;
  logic        tx_valid, busy;
  logic [7:0]  tx_data;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  bit rand_ready = 0;
  bit noise = 0;

  always #4 clk = ~clk;

  usb_tok_enc uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .pid_i(pid), .addr_i(addr),
    .endp_i(endp), .frame_i(frame), .tx_ready_i(ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .busy_o(busy)
  );

  // behavioural reference
  function automatic logic [4:0] ref_crc(input logic [10:0] f);
    logic [4:0] c = 5'h1f;
    for (int i = 0; i < 11; i++) begin
      logic fb = c[4] ^ f[i];
      c = {c[3:0], 1'b0};
      if (fb) c = c ^ 5'b00101;
    end
    return ~c;
  endfunction

  function automatic void ref_build(input logic [3:0] p, input logic [6:0] a,
                                    input logic [3:0] e, input logic [10:0] fr,
                                    ref logic [7:0] q[$]);
    logic [10:0] f;
    logic [4:0] c;
    logic [7:0] b2;
    q = {};
    q.push_back({~p, p});
    if (p[1:0] == 2'b10) return;
    f = (p == 4'b0101) ? fr : {e, a};
    c = ref_crc(f);
    b2 = {5'b0, f[10:8]};
    for (int i = 0; i < 5; i++) b2[3+i] = c[4-i];
    q.push_back(f[7:0]);
    q.push_back(b2);
  endfunction

  logic [7:0] m_q[$];
  logic [7:0] got[$];
  int  m_idx = 0;
  bit  m_busy = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0;
      m_idx = 0;
    end else if (m_busy) begin
      if (ready) begin
        m_idx++;
        if (m_idx == m_q.size()) m_busy = 0;
      end
    end else if (req) begin
      ref_build(pid, addr, endp, frame, m_q);
      m_idx = 0;
      m_busy = 1;
    end
  end

  // per-cycle compare and capture
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (tx_valid !== m_busy) begin
        fails++;
        $display("FAIL R7/R10 tx_valid: got %0b exp %0b at %0t", tx_valid, m_busy, $time);
      end
      if (busy !== m_busy) begin
        fails++;
        $display("FAIL R8/R9 busy: got %0b exp %0b at %0t", busy, m_busy, $time);
      end
      if (m_busy && tx_data !== m_q[m_idx]) begin
        fails++;
        $display("FAIL R1-byte%0d (R3 R4 R5 R6) data: got %h exp %h at %0t",
                 m_idx, tx_data, m_q[m_idx], $time);
      end
      if (tx_valid && ready) got.push_back(tx_data);
    end
  end

  always @(negedge clk) begin
    #1;
    if (rand_ready) ready = ($urandom % 3) != 0;
    else            ready = 1'b1;
  end

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles exp <150000", cycles);
      finish_run();
    end
  end

  task automatic send(input logic [3:0] p, input logic [6:0] a,
                      input logic [3:0] e, input logic [10:0] fr);
    @(negedge clk); #1;
    req = 1; pid = p; addr = a; endp = e; frame = fr;
    @(negedge clk); #1;
    req = 0;
    while (busy) begin
      if (noise) begin
        req = $urandom % 2; pid = 4'($urandom); addr = 7'($urandom);
        endp = 4'($urandom); frame = 11'($urandom);
      end
      @(negedge clk); #1;
    end
    req = 0;
    @(negedge clk);
  endtask

  task automatic check_got(input string tag, input logic [7:0] exp[$]);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %p exp %p", tag, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (tx_valid !== 1'b0 || busy !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset: got %0b%0b exp 00", tx_valid, busy);
    end
    #1 rst_n = 1;
    repeat (2) @(negedge clk);

    got = {};  send(4'b1101, 7'h00, 4'h0, 11'h0);
    check_got("R5 SETUP 0/0", '{8'h2d, 8'h00, 8'h10});
    got = {};  send(4'b0010, 7'h12, 4'h3, 11'h0);
    check_got("R2 ACK one byte", '{8'hd2});
    got = {};  send(4'b1010, 7'h7f, 4'hf, 11'h0);
    check_got("R2 NAK one byte", '{8'h5a});
    got = {};  send(4'b1001, 7'h55, 4'b1011, 11'h0);
    vectors++;
    if (got.size() != 3 || got[1] !== 8'hd5 || got[2][2:0] !== 3'b101) begin
      fails++;
      $display("FAIL R3 token field: got %p exp d5/xx101", got);
    end
    got = {};  send(4'b0101, 7'h00, 4'h0, 11'h6a3);
    vectors++;
    if (got.size() != 3 || got[1] !== 8'ha3 || got[2][2:0] !== 3'b110) begin
      fails++;
      $display("FAIL R4 sof field: got %p exp a3/xx110", got);
    end
    send(4'b0101, 7'h00, 4'h0, 11'h7ff);
    send(4'b0101, 7'h00, 4'h0, 11'h000);
    send(4'b0011, 7'h01, 4'h1, 11'h0);

    rand_ready = 1;
    for (int i = 0; i < 60; i++)
      send(4'($urandom), 7'($urandom), 4'($urandom), 11'($urandom));
    noise = 1;
    for (int i = 0; i < 60; i++)
      send(4'($urandom), 7'($urandom), 4'($urandom), 11'($urandom));
    noise = 0;

    // R8: back-to-back request while busy must be dropped
    @(negedge clk); #1;
    req = 1; pid = 4'b0001; addr = 7'h21; endp = 4'h2;
    @(negedge clk); #1;
    pid = 4'b0010;
    @(negedge clk); #1;
    req = 0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule